// File: doc/BRIEF.md
# Supervisor Reset Pulse Sequencer

This block merges three reset sources into a single active-low processor reset. Two of them are levels: a supply-undervoltage indication, given as a pair of comparator flags, and a manual-reset pin. The third is a one-clock watchdog fault strobe. While any level source is active the reset output stays low. Once every source has gone quiet, the output stays low for a timeout and then releases. The timeout length comes from a register value and is counted in pulses of a slow tick input.

The supply path takes two flags. One says the supply has fallen under the trip point. The other says it has climbed back above the trip point plus a hysteresis margin. An undervoltage is accepted only if the fall flag persists for a configurable number of system clocks, so brief dips are rejected. Once accepted, it is held until the rise flag reports recovery.

The manual-reset pin has its own persistence filter, which rejects glitches. A watchdog strobe has no duration of its own, so the block stretches it into one full timeout pulse. After reset, the output comes up asserted and runs one full timeout before its first release.

Top module: `supervisor_reset_seq`

## Requirements
- R1: During reset and after reset ends, `rst_out_n` is 0. With no request present, it rises on the clock edge that samples the T-th tick, where T is `tmo_limit_i`.
- R2: A low pulse on `mr_n_i` that is seen at fewer than MR_FILT consecutive clock edges causes no reset. A low pulse seen at MR_FILT or more consecutive edges always causes a reset.
- R3: `rst_out_n` falls MR_FILT+3 clock edges after the first edge that samples `mr_n_i` low. That edge counts as the first.
- R4: An undervoltage (`uv_fall_i`=1) seen at fewer than SUP_FILT consecutive edges causes no reset. One seen at SUP_FILT or more edges causes a reset, with `rst_out_n` falling SUP_FILT+3 edges after the first edge that samples it.
- R5: An accepted undervoltage stays active after `uv_fall_i` returns to 0. It clears only once `uv_rise_i`=1 with `uv_fall_i`=0.
- R6: After the last level request is withdrawn at the pins, `rst_out_n` stays 0. It rises on the edge that samples the T-th tick, counting only ticks sampled 3 or more clocks after the withdrawal.
- R7: A one-clock `wdt_fault_i` strobe drives `rst_out_n` to 0 on the next edge. The output is then held for exactly T ticks.
- R8: A watchdog strobe or a new level request during a running timeout discards the ticks counted so far. A full T ticks are then required again.
- R9: A `tmo_limit_i` of 0 behaves as 1, so the first counted tick releases the output.
- R10: Ticks that arrive while a level request is active are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick_i | input | 1 | Slow timebase pulse, one clock wide, synchronous to clk |
| tmo_limit_i | input | TMO_W | Timeout length in ticks (0 treated as 1) |
| uv_fall_i | input | 1 | 1 when the supply is below the falling trip point (asynchronous) |
| uv_rise_i | input | 1 | 1 when the supply is above trip point plus hysteresis (asynchronous) |
| mr_n_i | input | 1 | Manual reset, active low (asynchronous) |
| wdt_fault_i | input | 1 | Watchdog fault strobe, synchronous, one clock |
| rst_out_n | output | 1 | Processor reset, active low |

## Verification
The bench sweeps every manual-reset and supply-dip width up to about twice the filter length. A filter that is off by one would accept a pulse one clock too short or reject the shortest legal pulse, and a wrong pipeline depth would show up as a shifted assertion latency. For each timeout value in a small range, the bench counts release ticks one by one. This catches a counter that releases a tick early, keeps counting ticks while a request is held, or fails to restart when a watchdog strobe or manual reset arrives mid-timeout. A separate hysteresis case drops the fall flag while leaving the rise flag low. A design that releases on the fall flag alone would then deassert too early.

// File: rtl/rs_pkg.sv
// Package: shared types and helpers for the supervisor reset sequencer.
// Assumes: the three asynchronous pins travel together through one synchronizer.
package rs_pkg;

    // Asynchronous pins, grouped so that one synchronizer carries them.
    typedef struct packed {
        logic uv_fall;
        logic uv_rise;
        logic mr_n;
    } rs_pins_t;

    // Inactive pin values: supply good, manual reset released.
    localparam rs_pins_t PINS_IDLE = '{uv_fall: 1'b0, uv_rise: 1'b1, mr_n: 1'b1};

    // Width of a counter that must hold the values 0 .. n-1.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rs_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes: each bit is a slow level, so bits may be skewed by one clock
// relative to each other. STAGES >= 1.
module rs_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Purpose: capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= RST_VAL;
                    else        stg[gi] <= d;
                end
            end else begin : g_next
                // Purpose: pass the value along the metastability chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= RST_VAL;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rs_glitch_filter.sv
// Module: persistence filter. The output goes high once the input has been
// high at LEN consecutive edges, and drops on the first edge that sees the
// input low.
// Assumes: the input is already synchronous. LEN >= 1.
module rs_glitch_filter
    import rs_pkg::*;
#(
    parameter int unsigned LEN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_req,
    output logic req_q
);
    localparam int unsigned CW = cnt_bits(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    // Purpose: count consecutive active edges and raise the request at LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            req_q <= 1'b0;
        end else if (!raw_req) begin
            cnt   <= '0;
            req_q <= 1'b0;
        end else if (!req_q) begin
            if (cnt == LAST) req_q <= 1'b1;
            else             cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rs_supply_monitor.sv
// Module: undervoltage qualifier with two-flag hysteresis. A fall indication
// must persist for LEN consecutive edges before it is accepted. Once
// accepted, it holds until the rise flag reports recovery.
// Assumes: both flags are synchronous. LEN >= 1.
module rs_supply_monitor
    import rs_pkg::*;
#(
    parameter int unsigned LEN = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_s,
    input  logic rise_s,
    output logic under_q
);
    localparam int unsigned CW = cnt_bits(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;
    logic          recovered;

    // Recovery needs the upper flag set and the lower flag clear.
    assign recovered = rise_s && !fall_s;

    // Purpose: qualify dips by persistence and hold until recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            under_q <= 1'b0;
        end else if (under_q) begin
            cnt <= '0;
            if (recovered) under_q <= 1'b0;
        end else if (!fall_s) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            under_q <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rs_timeout.sv
// Module: reset hold timer. While restart is high it is held active with a
// cleared count. Otherwise it counts ticks and deactivates on the tick that
// brings the count to the limit. A limit of 0 acts as 1.
// Assumes: tick is a one-clock synchronous pulse. After reset it starts
// active, which gives the power-on timeout.
module rs_timeout #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          active_q
);
    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_inc;
    logic          reached;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign reached = cnt_inc >= {1'b0, limit};

    // Purpose: hold, count ticks, and release at the programmed length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            cnt      <= '0;
        end else if (restart) begin
            active_q <= 1'b1;
            cnt      <= '0;
        end else if (active_q && tick) begin
            if (reached) begin
                active_q <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt_inc[TW-1:0];
            end
        end
    end
endmodule

// File: rtl/supervisor_reset_seq.sv
// Module: top of the supervisor reset sequencer. It synchronizes the pins,
// filters the manual reset, qualifies the supply, and drives one
// active-low reset that is stretched by a tick-counted timeout.
// Assumes: tick_i and wdt_fault_i are synchronous to clk. The other inputs
// are asynchronous levels.
module supervisor_reset_seq
    import rs_pkg::*;
#(
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned SUP_FILT    = 4000,
    parameter int unsigned MR_FILT     = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic             uv_fall_i,
    input  logic             uv_rise_i,
    input  logic             mr_n_i,
    input  logic             wdt_fault_i,
    output logic             rst_out_n
);
    rs_pins_t pins_raw;
    rs_pins_t pins_s;
    logic     uv_fall_s;
    logic     uv_rise_s;
    logic     mr_low_s;
    logic     mr_req;
    logic     sup_under;
    logic     req_level;
    logic     hold_active;

    assign pins_raw = '{uv_fall: uv_fall_i, uv_rise: uv_rise_i, mr_n: mr_n_i};

    rs_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
    );

    assign uv_fall_s = pins_s.uv_fall;
    assign uv_rise_s = pins_s.uv_rise;
    assign mr_low_s  = !pins_s.mr_n;

    rs_glitch_filter #(.LEN(MR_FILT)) u_mr_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_req(mr_low_s),
        .req_q  (mr_req)
    );

    rs_supply_monitor #(.LEN(SUP_FILT)) u_supply (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_s (uv_fall_s),
        .rise_s (uv_rise_s),
        .under_q(sup_under)
    );

    assign req_level = mr_req || sup_under;

    rs_timeout #(.TW(TMO_W)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (req_level || wdt_fault_i),
        .tick    (tick_i),
        .limit   (tmo_limit_i),
        .active_q(hold_active)
    );

    assign rst_out_n = !hold_active;
endmodule

// File: rtl/rs_seq_checker.sv
// Module: assertion checker bound to supervisor_reset_seq.
// Assumes: it is attached through the bind below.
module rs_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic wdt_fault_i,
    input logic rst_out_n,
    input logic req_level,
    input logic sup_under,
    input logic uv_fall_s,
    input logic uv_rise_s,
    input logic mr_req,
    input logic mr_low_s
);
    assert_fault_pulls_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fault_i |=> !rst_out_n);

    assert_level_holds_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_level |=> !rst_out_n);

    assert_release_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(tick_i) && !$past(req_level) && !$past(wdt_fault_i)));

    assert_hysteresis_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_under && !uv_rise_s) |=> sup_under);

    assert_supply_needs_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sup_under) |-> $past(uv_fall_s));

    assert_mr_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req |-> $past(mr_low_s));
endmodule

bind supervisor_reset_seq rs_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wdt_fault_i(wdt_fault_i),
    .rst_out_n  (rst_out_n),
    .req_level  (req_level),
    .sup_under  (sup_under),
    .uv_fall_s  (uv_fall_s),
    .uv_rise_s  (uv_rise_s),
    .mr_req     (mr_req),
    .mr_low_s   (mr_low_s)
);

// File: tb/tb_supervisor_reset_seq.sv
module tb_supervisor_reset_seq;
    localparam int TW  = 8;
    localparam int SUP = 6;
    localparam int MRF = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic [TW-1:0] tmo_limit_i = 8'd4;
    logic          uv_fall_i = 1'b0;
    logic          uv_rise_i = 1'b1;
    logic          mr_n_i = 1'b1;
    logic          wdt_fault_i = 1'b0;
    logic          rst_out_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    supervisor_reset_seq #(
        .TMO_W(TW), .SUP_FILT(SUP), .MR_FILT(MRF), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tmo_limit_i(tmo_limit_i),
        .uv_fall_i(uv_fall_i), .uv_rise_i(uv_rise_i), .mr_n_i(mr_n_i),
        .wdt_fault_i(wdt_fault_i), .rst_out_n(rst_out_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One tick pulse, two clocks long including its gap.
    task automatic one_tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        @(negedge clk);
    endtask

    // The output must be held now, and must rise exactly on the t-th tick.
    task automatic expect_release(input int t, input string req);
        check(rst_out_n == 1'b0, req, rst_out_n, 0);
        for (int i = 1; i <= t; i++) begin
            one_tick();
            check(rst_out_n == (i == t), req, rst_out_n, (i == t));
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lat;
        // R1: reset state and power-on timeout
        clocks(3);
        check(rst_out_n == 1'b0, "R1", rst_out_n, 0);
        rst_n = 1'b1;
        clocks(6);
        check(rst_out_n == 1'b0, "R1", rst_out_n, 0);
        expect_release(4, "R1");

        // R2/R3/R6: manual-reset width sweep
        for (int w = 1; w <= 2 * MRF + 1; w++) begin
            lat = 0;
            mr_n_i = 1'b0;
            for (int c = 1; c <= w + MRF + 6; c++) begin
                @(negedge clk);
                if (c == w) mr_n_i = 1'b1;
                if (!rst_out_n && lat == 0) lat = c;
            end
            if (w < MRF) check(lat == 0, "R2", lat, 0);
            else begin
                check(lat == MRF + 3, "R3", lat, MRF + 3);
                expect_release(4, "R6");
            end
        end

        // R4/R6: supply dip width sweep
        for (int w = 1; w <= 2 * SUP; w++) begin
            lat = 0;
            uv_fall_i = 1'b1;
            uv_rise_i = 1'b0;
            for (int c = 1; c <= w + SUP + 6; c++) begin
                @(negedge clk);
                if (c == w) begin
                    uv_fall_i = 1'b0;
                    uv_rise_i = 1'b1;
                end
                if (!rst_out_n && lat == 0) lat = c;
            end
            if (w < SUP) check(lat == 0, "R4", lat, 0);
            else begin
                check(lat == SUP + 3, "R4", lat, SUP + 3);
                expect_release(4, "R6");
            end
        end

        // R5: hysteresis, fall flag drops but rise flag stays low
        uv_fall_i = 1'b1;
        uv_rise_i = 1'b0;
        clocks(SUP + 4);
        uv_fall_i = 1'b0;
        clocks(5);
        for (int i = 0; i < 8; i++) one_tick();
        check(rst_out_n == 1'b0, "R5", rst_out_n, 0);
        uv_rise_i = 1'b1;
        clocks(5);
        expect_release(4, "R5");

        // R10: ticks during a held manual reset are not counted
        mr_n_i = 1'b0;
        clocks(MRF + 4);
        for (int i = 0; i < 10; i++) one_tick();
        check(rst_out_n == 1'b0, "R10", rst_out_n, 0);
        mr_n_i = 1'b1;
        clocks(5);
        expect_release(4, "R10");

        // R7: watchdog strobe, sweep of timeout lengths
        for (int t = 1; t <= 6; t++) begin
            tmo_limit_i = TW'(t);
            wdt_fault_i = 1'b1;
            @(negedge clk);
            wdt_fault_i = 1'b0;
            check(rst_out_n == 1'b0, "R7", rst_out_n, 0);
            expect_release(t, "R7");
        end

        // R8: restart by a second strobe, then by a manual reset
        tmo_limit_i = 8'd5;
        wdt_fault_i = 1'b1;
        @(negedge clk);
        wdt_fault_i = 1'b0;
        one_tick();
        one_tick();
        one_tick();
        wdt_fault_i = 1'b1;
        @(negedge clk);
        wdt_fault_i = 1'b0;
        expect_release(5, "R8");
        wdt_fault_i = 1'b1;
        @(negedge clk);
        wdt_fault_i = 1'b0;
        one_tick();
        one_tick();
        mr_n_i = 1'b0;
        clocks(MRF + 4);
        mr_n_i = 1'b1;
        clocks(5);
        expect_release(5, "R8");

        // R9: a limit of 0 releases on the first tick
        tmo_limit_i = '0;
        wdt_fault_i = 1'b1;
        @(negedge clk);
        wdt_fault_i = 1'b0;
        expect_release(1, "R9");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule